// File: doc/BRIEF.md
# Periodic Down-Counter Timer

A single-channel timer that counts down from a programmed period and restarts from it each time it expires. It sits on a plain 32-bit register bus with one-cycle accesses: reads are combinational while `bus_en_i` is high and `bus_we_i` is low, and a write takes effect at the clock edge that samples it. Counting is paced by `tick_i`, a clock-enable pulse with a nominal rate of 1 MHz. The tick passes through a prescaler that divides it by 1, 16 or 256 before it reaches the counter.

Each expiry sets a latched interrupt flag. Software clears the flag by writing any value to the acknowledge register. `irq_o` is a level output that is high while the flag is set and the interrupt enable is on. There are two ways to set the period. One restarts the count at once. The other only changes the value loaded at the next wrap, so the current interval is not disturbed. The bus carries only register accesses and has no streaming data, so it has no valid/ready handshake. Every access completes in the cycle it is presented.

The register window is 1 KB. The bus address port carries the word index, which is the byte offset divided by four. In the register table, offset means byte offset.

Top module: `tmr_periodic`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set, counting off). The period, the value register and the raw flag read 0, and `irq_o` is low.
- R2: A write to offset 0x00 stores the period and restarts the count from it at once. Reading offset 0x00 or offset 0x18 returns the stored period.
- R3: A write to offset 0x18 stores the period and leaves the running count untouched. The new period is loaded at the next wrap.
- R4: While control bit 7 is set, each prescaled step decrements the count. A step taken at count 0 reloads the period and sets the raw flag, so a period p gives an interval of p+1 steps. A control write with bit 7 set reloads the count from the period.
- R5: Control bits [3:2] choose the prescale ratio: 00 divides by 1, 01 by 16, 10 by 256, and 11 by 1. Ticks are counted only while bit 7 is set, and every control write clears the prescaler phase.
- R6: Control bit 1 selects the counter width. When the bit is 0, the count uses only the low 16 bits of the period and the value register at offset 0x04 reads zero-extended. When the bit is 1, all 32 bits are used.
- R7: Any write to offset 0x0C clears the raw flag. An expiry in the same cycle wins over the clear. A read of offset 0x0C returns 0x544D5241.
- R8: Offset 0x10 returns the raw flag in bit 0, and offset 0x14 returns that flag ANDed with control bit 5. `irq_o` is high only while both the flag and bit 5 are set.
- R9: The control register keeps only bits 7, 5, 3:2 and 1. All other bits read 0.
- R10: While control bit 7 is clear, the count and the raw flag hold, whatever `tick_i` does.
- R11: Reads of offsets 0x1C through 0x3FC return 0. Writes to those offsets and to offset 0x04 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-rate clock enable, before the prescaler |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W-2 | Word index into the 1 KB window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 10-bit byte window (8-bit word index) and an 8-bit prescaler stage. With these values the last word of the window, offset 0x3FC, can be addressed, and the divide-by-256 ratio needs only 256 ticks, so both can be exercised. With a 16-bit narrow width, a period above 0xFFFF shows a different value in narrow mode and in wide mode, which lets the bench tell the two widths apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Word indices within the register window
  localparam logic [7:0] OFS_LOAD  = 8'h00;
  localparam logic [7:0] OFS_VALUE = 8'h01;
  localparam logic [7:0] OFS_CTRL  = 8'h02;
  localparam logic [7:0] OFS_ACK   = 8'h03;
  localparam logic [7:0] OFS_RAW   = 8'h04;
  localparam logic [7:0] OFS_MSK   = 8'h05;
  localparam logic [7:0] OFS_BGLD  = 8'h06;

  // Control bit positions
  localparam int CB_WIDE = 1;
  localparam int CB_PRE  = 2;
  localparam int CB_IE   = 5;
  localparam int CB_EN   = 7;

  localparam logic [31:0] ACK_TAG = 32'h544D_5241;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV16  = 2'b01,
    PRE_DIV256 = 2'b10,
    PRE_ALT1   = 2'b11
  } pre_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int STAGE_W = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     run,
  input  logic     tick,
  input  pre_sel_e sel,
  output logic     step
);
  localparam logic [STAGE_W-1:0] MID_MASK = STAGE_W'(15);
  localparam logic [STAGE_W-1:0] TOP_MASK = {STAGE_W{1'b1}};

  logic [STAGE_W-1:0] phase_q;
  logic [STAGE_W-1:0] mask;

  always_comb begin
    unique case (sel)
      PRE_DIV16:  mask = MID_MASK;
      PRE_DIV256: mask = TOP_MASK;
      default:    mask = '0;
    endcase
  end

  assign step = run && tick && ((phase_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) phase_q <= '0;
    else if (run && tick) phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W        = 32,
  parameter int NARROW_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         wide,
  input  logic [W-1:0] period,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] NARROW_MASK = {{(W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] mask;
  logic [W-1:0] cur;

  assign mask   = wide ? {W{1'b1}} : NARROW_MASK;
  assign cur    = cnt_q & mask;
  assign count  = cur;
  assign expire = step && !restart && (cur == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (restart)     cnt_q <= period & mask;
    else if (step) begin
      if (cur == '0)      cnt_q <= period & mask;
      else                cnt_q <= (cur - 1'b1) & mask;
    end
  end
endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 10,
  parameter int NARROW_W = 16,
  parameter int STAGE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:2] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic wr, rd;
  logic wr_load, wr_ctrl, wr_ack, wr_bgld;

  logic [DATA_W-1:0] period_q, period_nxt;
  logic en_q, ie_q, wide_q, wide_nxt;
  pre_sel_e pre_q;
  logic flag_q;

  logic step, expire, restart;
  logic [DATA_W-1:0] cnt_val;

  assign word    = bus_addr_i;
  assign wr      = bus_en_i && bus_we_i;
  assign rd      = bus_en_i && !bus_we_i;
  assign wr_load = wr && (word == WORD_W'(OFS_LOAD));
  assign wr_ctrl = wr && (word == WORD_W'(OFS_CTRL));
  assign wr_ack  = wr && (word == WORD_W'(OFS_ACK));
  assign wr_bgld = wr && (word == WORD_W'(OFS_BGLD));

  assign period_nxt = (wr_load || wr_bgld) ? bus_wdata_i : period_q;
  assign wide_nxt   = wr_ctrl ? bus_wdata_i[CB_WIDE] : wide_q;
  assign restart    = wr_load || (wr_ctrl && bus_wdata_i[CB_EN]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      en_q     <= 1'b0;
      ie_q     <= 1'b1;
      wide_q   <= 1'b0;
      pre_q    <= PRE_DIV1;
      flag_q   <= 1'b0;
    end else begin
      period_q <= period_nxt;
      if (wr_ctrl) begin
        en_q   <= bus_wdata_i[CB_EN];
        ie_q   <= bus_wdata_i[CB_IE];
        wide_q <= bus_wdata_i[CB_WIDE];
        pre_q  <= pre_sel_e'(bus_wdata_i[CB_PRE+1:CB_PRE]);
      end
      if (expire)      flag_q <= 1'b1;
      else if (wr_ack) flag_q <= 1'b0;
    end
  end

  tmr_prescale #(.STAGE_W(STAGE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wr_ctrl),
    .run  (en_q),
    .tick (tick_i),
    .sel  (pre_q),
    .step (step)
  );

  tmr_count #(.W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .wide   (wide_nxt),
    .period (period_nxt),
    .step   (step),
    .count  (cnt_val),
    .expire (expire)
  );

  assign irq_o = flag_q && ie_q;

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (word)
        WORD_W'(OFS_LOAD), WORD_W'(OFS_BGLD): bus_rdata_o = period_q;
        WORD_W'(OFS_VALUE): bus_rdata_o = cnt_val;
        WORD_W'(OFS_CTRL): begin
          bus_rdata_o[CB_EN]              = en_q;
          bus_rdata_o[CB_IE]              = ie_q;
          bus_rdata_o[CB_WIDE]            = wide_q;
          bus_rdata_o[CB_PRE+1:CB_PRE]    = pre_q;
        end
        WORD_W'(OFS_ACK): bus_rdata_o = DATA_W'(ACK_TAG);
        WORD_W'(OFS_RAW): bus_rdata_o[0] = flag_q;
        WORD_W'(OFS_MSK): bus_rdata_o[0] = flag_q && ie_q;
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_periodic_chk.sv
module tmr_periodic_chk
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:2] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              irq_o,
  input logic              flag_q,
  input logic              ie_q,
  input logic              en_q,
  input logic              wide_q,
  input logic              expire,
  input logic [DATA_W-1:0] cnt_val
);
  localparam int WORD_W = ADDR_W - 2;
  logic any_wr, ack_wr, load_wr;
  assign any_wr  = bus_en_i && bus_we_i;
  assign ack_wr  = any_wr && (bus_addr_i == WORD_W'(OFS_ACK));
  assign load_wr = any_wr && (bus_addr_i == WORD_W'(OFS_LOAD));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !expire) |=> !flag_q);

  // R4
  expire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q && ie_q));

  // R2
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && wide_q) |=> (cnt_val == $past(bus_wdata_i)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !any_wr) |=> ($stable(cnt_val) && $stable(flag_q)));
endmodule

bind tmr_periodic tmr_periodic_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en_i   (bus_en_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .flag_q     (flag_q),
  .ie_q       (ie_q),
  .en_q       (en_q),
  .wide_q     (wide_q),
  .expire     (expire),
  .cnt_val    (cnt_val)
);

// File: tb/tmr_periodic_bench.sv
module tmr_periodic_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:2]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  tmr_periodic u_tmr_periodic (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .bus_en_i   (bus_en),
    .bus_we_i   (bus_we),
    .bus_addr_i (bus_addr),
    .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata),
    .irq_o      (irq)
  );

  // Monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && bus_en && !bus_we) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL unexpected read: got %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[9:2]; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[9:2];
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq: got %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(10'h008, 32'h20, "R1 ctrl");
    rd(10'h000, 32'h0, "R1 period");
    rd(10'h004, 32'h0, "R1 value");
    rd(10'h010, 32'h0, "R1 raw");
    rd(10'h014, 32'h0, "R1 masked");
    // R7 ack read constant
    rd(10'h00C, 32'h544D5241, "R7 ack tag");

    // R2 load restarts at once
    wr(10'h000, 32'd5);
    rd(10'h004, 32'd5, "R2 value after load");
    // R4 enable, ie, wide, div1
    wr(10'h008, 32'hA2);
    ticks(5);
    rd(10'h004, 32'd0, "R4 value at zero");
    rd(10'h010, 32'd0, "R4 no flag before wrap");
    ticks(1);
    rd(10'h004, 32'd5, "R4 reload on wrap");
    rd(10'h010, 32'd1, "R8 raw set");
    rd(10'h014, 32'd1, "R8 masked set");
    chk_irq(1'b1, "R8");
    wr(10'h00C, 32'h0);
    rd(10'h010, 32'd0, "R7 cleared by ack");
    chk_irq(1'b0, "R7");

    // R3 background reload
    wr(10'h018, 32'd2);
    rd(10'h004, 32'd5, "R3 count untouched");
    rd(10'h000, 32'd2, "R2 load reads period");
    rd(10'h018, 32'd2, "R2 bgld reads period");
    ticks(6);
    rd(10'h004, 32'd2, "R3 new period at wrap");
    rd(10'h010, 32'd1, "R3 flag at wrap");
    wr(10'h00C, 32'h0);

    // R8 interrupt disabled
    wr(10'h008, 32'h82);
    ticks(3);
    rd(10'h010, 32'd1, "R8 raw with ie off");
    rd(10'h014, 32'd0, "R8 masked with ie off");
    chk_irq(1'b0, "R8 ie off");

    // R5 divide by 16
    wr(10'h008, 32'h86);
    ticks(15);
    rd(10'h004, 32'd2, "R5 div16 before 16th");
    ticks(1);
    rd(10'h004, 32'd1, "R5 div16 at 16th");
    ticks(16);
    rd(10'h004, 32'd0, "R5 div16 second step");
    // R5 divide by 256
    wr(10'h008, 32'h8A);
    ticks(255);
    rd(10'h004, 32'd2, "R5 div256 before 256th");
    ticks(1);
    rd(10'h004, 32'd1, "R5 div256 at 256th");
    // R5 code 11 divides by 1
    wr(10'h008, 32'h8E);
    ticks(1);
    rd(10'h004, 32'd1, "R5 code11 div1");

    // R6 narrow mode
    wr(10'h008, 32'h00);
    wr(10'h000, 32'h0001_0003);
    rd(10'h004, 32'd3, "R6 narrow load");
    rd(10'h000, 32'h0001_0003, "R6 period stored full");
    wr(10'h008, 32'h80);
    ticks(4);
    rd(10'h004, 32'd3, "R6 narrow wrap");

    // R10 hold when disabled
    wr(10'h008, 32'h02);
    rd(10'h010, 32'd1, "R10 flag before idle");
    ticks(10);
    rd(10'h004, 32'd3, "R10 count held");
    rd(10'h010, 32'd1, "R10 flag held");

    // R11 unmapped and read-only
    rd(10'h01C, 32'h0, "R11 read 0x1C");
    rd(10'h3FC, 32'h0, "R11 read 0x3FC");
    wr(10'h004, 32'h55);
    wr(10'h020, 32'hFFFF);
    wr(10'h3FC, 32'h1);
    rd(10'h004, 32'd3, "R11 value unchanged");
    rd(10'h000, 32'h0001_0003, "R11 period unchanged");
    rd(10'h008, 32'h02, "R11 ctrl unchanged");
    rd(10'h010, 32'd1, "R11 flag unchanged");

    // R9 control keeps defined bits; R6 wide restart
    wr(10'h008, 32'hFFFF_FFFF);
    rd(10'h008, 32'hAE, "R9 ctrl readback");
    rd(10'h004, 32'h0001_0003, "R6 wide restart");
    chk_irq(1'b1, "R8 flag and ie");
    wr(10'h008, 32'h00);

    // R7 expiry wins over ack in same cycle
    wr(10'h000, 32'd0);
    wr(10'h008, 32'hA2);
    @(posedge clk); #1 tick = 1'b1;
    wr(10'h00C, 32'h0);
    rd(10'h010, 32'd1, "R7 expiry beats ack");
    @(posedge clk); #1 tick = 1'b0;
    wr(10'h00C, 32'h0);
    rd(10'h010, 32'd0, "R7 ack after ticks stop");

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule